// File: doc/BRIEF.md
# Multi-Lane Serial SRAM Controller

This block is the host side of a link to an external 128K x 8 serial SRAM. It drives chip-select, a serial clock and four bidirectional data lanes, each with its own output enable. A local port accepts one byte request at a time: a read, a write or a lane-mode change. A read or write may be extended into a sequential burst. The memory advances its address after every data byte, so each further byte of a burst only needs another request on the local port.

The controller tracks whether the bus is in single, dual or quad lane mode. Every byte it sends, the mode-change command included, goes out at the width of the mode active at that moment. It builds the command, address, dummy and data phases from that width. It releases the lanes when read data is due to come back. Between bytes of a burst the serial clock is held low with chip-select still asserted. The serial clock is the system clock divided by `CLK_DIV` (at least 2).

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, io_oe is 0, lane_mode is 0 (single) and req_ready is 1.
- R2: A request with req_op[1]=1 sends a command byte and nothing else, then updates lane_mode. The target is quad (2) if req_wdata[1] is set, dual (1) if only req_wdata[0] is set, and single (0) otherwise. The command codes are 0x38 for quad, 0x3B for dual and 0xFF for single. The new mode persists across later transactions, and lane_mode only changes while cs_n is low.
- R3: Command and address bytes take 8, 4 or 2 sck rising edges per byte in single, dual or quad mode (lane_mode 0, 1, 2). A 0xFF sent in quad mode therefore takes 2 edges.
- R4: A read (req_op=00) sends 0x03 and a write (req_op=01) sends 0x02. Either is followed by a 24-bit address, most significant byte first, with req_addr in the low bits and zeros above.
- R5: Bytes go out MSB first. In single mode io_out[0] carries each bit and io_oe is 0001. In dual mode io_out[1:0] carries bit pairs, the higher bit on lane 1, and io_oe is 0011. In quad mode io_out[3:0] carries bits 7..4 and then 3..0, and io_oe is 1111. io_oe never takes any other nonzero value.
- R6: A read inserts one byte-time of dummy clocks after the address: 8, 4 or 2 clocks. All lanes stay released (io_oe=0) through the dummy and data phases.
- R7: A write sends its data bytes directly after the address, with no dummy clocks.
- R8: Read data is sampled on the sck rising edge: from io_in[1] in single mode, from io_in[1:0] in dual mode and from io_in[3:0] in quad mode. Each completed byte pulses rd_valid for one cycle with rd_data.
- R9: If a data byte was requested with req_last=0, cs_n stays low after that byte and sck stays low with req_ready=1. The next accepted request continues the burst at the next sequential address.
- R10: At the end of a transaction io_oe is 0 for at least CLK_DIV system clocks before cs_n rises. cs_n then stays high for at least CLK_DIV system clocks.
- R11: sck is low whenever cs_n is high. io_out and io_oe change only while sck is low.
- R12: req_ready is 1 only when the controller is idle or holding a burst. A request is accepted on a clock edge where req_valid and req_ready are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 00 read, 01 write, 1x mode change |
| req_addr | input | ADDR_W | Byte address (first byte of a transaction) |
| req_wdata | input | 8 | Write data, or mode target in bits 1:0 |
| req_last | input | 1 | This byte ends the transaction |
| req_ready | output | 1 | Controller can accept a request |
| rd_valid | output | 1 | One-cycle strobe for a read byte |
| rd_data | output | 8 | Read byte |
| lane_mode | output | 2 | Active mode: 0 single, 1 dual, 2 quad |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip-select, active low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
Some behaviours are checked on every cycle. These are the clock gating by chip-select, the stability of the lanes while sck is high, the legal enable patterns, the release of all lanes before chip-select rises, the minimum deselect gap, and mode changes happening only while selected. The other behaviours need a serial memory model that responds to the lanes, and only the bench scenarios can show them. These are the command code, the address bytes, the clock count per transaction in each mode, dummy insertion for reads only, and the bytes that come back from a burst. The scenarios walk through every mode transition, including returns to single from quad and dual, and run write bursts with stalls followed by overlapping read bursts.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  input  logic              req_last,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic [1:0]        lane_mode,
  output logic              sck,
  output logic              cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);
  localparam int DW = $clog2(CLK_DIV);
  localparam logic [DW-1:0] RISE_AT = DW'(CLK_DIV / 2 - 1);
  localparam logic [DW-1:0] LAST_AT = DW'(CLK_DIV - 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_DUMMY, S_DATA, S_HOLD, S_TAIL, S_GAP} st_t;

  st_t          st;
  logic [DW-1:0] div_cnt;
  logic [2:0]   slot;
  logic [1:0]   bidx, op_q, mode_q;
  logic [7:0]   osh, ish, wdata_q;
  logic [23:0]  addr_q;
  logic         last_q;

  function automatic logic [3:0] lanes_of(input logic [7:0] b, input logic [1:0] m);
    case (m)
      2'd0:    return {3'b000, b[7]};
      2'd1:    return {2'b00, b[7:6]};
      default: return b[7:4];
    endcase
  endfunction

  function automatic logic [3:0] mask_of(input logic [1:0] m);
    case (m)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [7:0] shl(input logic [7:0] b, input logic [1:0] m);
    case (m)
      2'd0:    return {b[6:0], 1'b0};
      2'd1:    return {b[5:0], 2'b00};
      default: return {b[3:0], 4'b0000};
    endcase
  endfunction

  function automatic logic [7:0] addr_byte(input logic [23:0] a, input logic [1:0] i);
    case (i)
      2'd0:    return a[23:16];
      2'd1:    return a[15:8];
      default: return a[7:0];
    endcase
  endfunction

  logic [1:0] tgt_mode;
  logic [7:0] cmd_code;
  logic [7:0] osh_next;
  logic       slot_end;
  logic [7:0] ish_next;

  assign tgt_mode  = req_wdata[1] ? 2'd2 : (req_wdata[0] ? 2'd1 : 2'd0);
  assign cmd_code  = req_op[1] ? (tgt_mode == 2'd2 ? 8'h38 : tgt_mode == 2'd1 ? 8'h3B : 8'hFF)
                               : (req_op[0] ? 8'h02 : 8'h03);
  assign osh_next  = shl(osh, mode_q);
  assign slot_end  = slot == (3'd7 >> mode_q);
  assign ish_next  = mode_q == 2'd0 ? {ish[6:0], io_in[1]} :
                     mode_q == 2'd1 ? {ish[5:0], io_in[1:0]} : {ish[3:0], io_in};
  assign req_ready = (st == S_IDLE) || (st == S_HOLD);
  assign lane_mode = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; div_cnt <= '0; slot <= '0; bidx <= '0; op_q <= '0; mode_q <= 2'd0;
      osh <= '0; ish <= '0; wdata_q <= '0; addr_q <= '0; last_q <= 1'b0;
      sck <= 1'b0; cs_n <= 1'b1; io_out <= '0; io_oe <= '0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q    <= req_op[1] ? 2'd2 : {1'b0, req_op[0]};
          addr_q  <= 24'(req_addr);
          wdata_q <= req_wdata;
          last_q  <= req_last;
          cs_n    <= 1'b0;
          div_cnt <= '0;
          slot    <= '0;
          osh     <= cmd_code;
          io_out  <= lanes_of(cmd_code, mode_q);
          io_oe   <= mask_of(mode_q);
          st      <= S_CMD;
        end
        S_CMD, S_ADDR, S_DUMMY, S_DATA: begin
          div_cnt <= (div_cnt == LAST_AT) ? '0 : div_cnt + 1'b1;
          if (div_cnt == RISE_AT) begin
            sck <= 1'b1;
            ish <= ish_next;
          end
          if (div_cnt == LAST_AT) begin
            sck <= 1'b0;
            if (!slot_end) begin
              slot   <= slot + 1'b1;
              osh    <= osh_next;
              io_out <= lanes_of(osh_next, mode_q);
            end else begin
              slot <= '0;
              case (st)
                S_CMD: if (op_q == 2'd2) begin
                  mode_q  <= tgt_q;
                  io_oe   <= '0;
                  div_cnt <= '0;
                  st      <= S_TAIL;
                end else begin
                  bidx   <= 2'd0;
                  osh    <= addr_q[23:16];
                  io_out <= lanes_of(addr_q[23:16], mode_q);
                  st     <= S_ADDR;
                end
                S_ADDR: if (bidx != 2'd2) begin
                  bidx   <= bidx + 1'b1;
                  osh    <= addr_byte(addr_q, bidx + 1'b1);
                  io_out <= lanes_of(addr_byte(addr_q, bidx + 1'b1), mode_q);
                end else if (op_q == 2'd0) begin
                  io_oe <= '0;
                  st    <= S_DUMMY;
                end else begin
                  osh    <= wdata_q;
                  io_out <= lanes_of(wdata_q, mode_q);
                  st     <= S_DATA;
                end
                S_DUMMY: st <= S_DATA;
                default: begin
                  if (op_q == 2'd0) begin
                    rd_valid <= 1'b1;
                    rd_data  <= ish;
                  end
                  io_oe   <= '0;
                  div_cnt <= '0;
                  st      <= last_q ? S_TAIL : S_HOLD;
                end
              endcase
            end
          end
        end
        S_HOLD: if (req_valid) begin
          last_q  <= req_last;
          div_cnt <= '0;
          st      <= S_DATA;
          if (op_q == 2'd1) begin
            osh    <= req_wdata;
            io_out <= lanes_of(req_wdata, mode_q);
            io_oe  <= mask_of(mode_q);
          end
        end
        S_TAIL: begin
          div_cnt <= div_cnt + 1'b1;
          if (div_cnt == LAST_AT) begin
            cs_n    <= 1'b1;
            div_cnt <= '0;
            st      <= S_GAP;
          end
        end
        default: begin
          div_cnt <= div_cnt + 1'b1;
          if (div_cnt == LAST_AT) begin
            div_cnt <= '0;
            st      <= S_IDLE;
          end
        end
      endcase
    end
  end

  logic [1:0] tgt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt_q <= 2'd0;
    else if (st == S_IDLE && req_valid) tgt_q <= tgt_mode;
  end
endmodule

module sram_lane_ctrl_chk #(
  parameter int CLK_DIV = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       cs_n,
  input logic [3:0] io_out,
  input logic [3:0] io_oe,
  input logic [1:0] lane_mode,
  input logic       req_ready,
  input logic       rd_valid
);
  logic [15:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= 16'(CLK_DIV);
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt < 16'(CLK_DIV)) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_sck_gated_R11: assert property (@(posedge clk) disable iff (!rst_n) sck |-> !cs_n);
  assert_lanes_still_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> ($stable(io_out) && $stable(io_oe)));
  assert_oe_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000 || io_oe == 4'b0001 || io_oe == 4'b0011 || io_oe == 4'b1111));
  assert_release_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (io_oe == 4'b0000 && $past(io_oe) == 4'b0000));
  assert_deselect_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> hi_cnt >= 16'(CLK_DIV));
  assert_mode_while_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode != $past(lane_mode)) |-> !cs_n);
  assert_ready_clock_low_R12: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !sck);
  assert_rd_in_txn_R8: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> !cs_n);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe),
  .lane_mode(lane_mode), .req_ready(req_ready), .rd_valid(rd_valid)
);

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
  localparam int CLK_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [16:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_last = 1'b0;
  logic req_ready, rd_valid, sck, cs_n;
  logic [7:0] rd_data;
  logic [1:0] lane_mode;
  logic [3:0] io_out, io_oe, io_in;
  logic [3:0] drv_oe = 4'b0, drv_val = 4'b0;

  always #5 clk = ~clk;

  assign io_in = (io_oe & io_out) | (~io_oe & drv_oe & drv_val);

  sram_lane_ctrl #(.CLK_DIV(CLK_DIV), .ADDR_W(17)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_last(req_last), .req_ready(req_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .lane_mode(lane_mode), .sck(sck), .cs_n(cs_n), .io_out(io_out),
    .io_oe(io_oe), .io_in(io_in)
  );

  // serial memory model
  logic [7:0] mem [0:255];
  logic [1:0] m_mode;
  int m_bits, m_bytes, m_dummy, m_rises, viol_dummy, viol_cont;
  logic [7:0] m_buf, m_cmd, cap_cmd;
  logic [23:0] m_addr, m_ptr, cap_addr;
  int cap_rises;

  always @(posedge sck or posedge cs_n or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
      m_mode = 2'd0; m_bits = 0; m_bytes = 0; m_dummy = 0; m_rises = 0; m_buf = 0; m_cmd = 0;
      m_addr = 0; m_ptr = 0; viol_dummy = 0; viol_cont = 0; cap_cmd = 0; cap_addr = 0; cap_rises = 0;
    end else if (cs_n) begin
      cap_cmd = m_cmd; cap_addr = m_addr; cap_rises = m_rises;
      m_bits = 0; m_bytes = 0; m_dummy = 0; m_rises = 0; m_buf = 0; m_cmd = 0;
    end else begin
      m_rises++;
      if ((io_oe & drv_oe) != 4'b0) viol_cont++;
      if (m_dummy > 0) begin
        if (io_oe != 4'b0) viol_dummy++;
        m_dummy--;
      end else begin
        if (m_cmd == 8'h03 && m_bytes >= 4 && io_oe != 4'b0) viol_dummy++;
        case (m_mode)
          2'd0:    m_buf = {m_buf[6:0], io_in[0]};
          2'd1:    m_buf = {m_buf[5:0], io_in[1:0]};
          default: m_buf = {m_buf[3:0], io_in};
        endcase
        m_bits += 1 << m_mode;
        if (m_bits == 8) begin
          m_bits = 0;
          m_bytes++;
          if (m_bytes == 1) begin
            m_cmd = m_buf;
            if (m_buf == 8'hFF) m_mode = 2'd0;
            if (m_buf == 8'h3B) m_mode = 2'd1;
            if (m_buf == 8'h38) m_mode = 2'd2;
          end else if (m_cmd == 8'h02 || m_cmd == 8'h03) begin
            if (m_bytes == 2) m_addr[23:16] = m_buf;
            if (m_bytes == 3) m_addr[15:8] = m_buf;
            if (m_bytes == 4) begin
              m_addr[7:0] = m_buf;
              m_ptr = m_addr;
              if (m_cmd == 8'h03) m_dummy = 8 >> m_mode;
            end
            if (m_cmd == 8'h03 && m_bytes >= 4) begin
              m_buf = mem[m_ptr[7:0]];
              m_ptr = m_ptr + 1;
            end
            if (m_cmd == 8'h02 && m_bytes > 4) begin
              mem[m_ptr[7:0]] = m_buf;
              m_ptr = m_ptr + 1;
            end
          end
        end
      end
    end
  end

  always @(negedge sck or posedge cs_n) begin
    if (cs_n) drv_oe = 4'b0;
    else if (m_dummy == 0 && m_cmd == 8'h03 && m_bytes >= 4) begin
      case (m_mode)
        2'd0:    begin drv_oe = 4'b0010; drv_val = {2'b00, m_buf[7], 1'b0}; end
        2'd1:    begin drv_oe = 4'b0011; drv_val = {2'b00, m_buf[7:6]}; end
        default: begin drv_oe = 4'b1111; drv_val = m_buf[7:4]; end
      endcase
    end else drv_oe = 4'b0;
  end

  // cycle monitors
  logic prev_cs = 1'b1;
  int quiet = 0, high_cnt = 1000, viol_r9 = 0, viol_r10 = 0, viol_r11 = 0, rd_total = 0;
  logic [7:0] rd_buf [0:63];
  always @(negedge clk) begin
    if (rd_valid) begin rd_buf[rd_total % 64] = rd_data; rd_total++; end
    if (cs_n && sck) viol_r11++;
    if (req_ready && !cs_n && sck) viol_r9++;
    if (!prev_cs && cs_n && quiet < CLK_DIV) viol_r10++;
    if (prev_cs && !cs_n && high_cnt < CLK_DIV) viol_r10++;
    quiet = (!cs_n && io_oe == 4'b0) ? quiet + 1 : 0;
    high_cnt = cs_n ? high_cnt + 1 : 0;
    prev_cs = cs_n;
  end

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  logic [7:0] exp_mem [0:255];
  logic [1:0] cur;

  task automatic send(input logic [1:0] op, input logic [16:0] a, input logic [7:0] d, input logic last);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; req_last = last;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!(req_ready && cs_n)) @(negedge clk);
  endtask

  function automatic int slots(input logic [1:0] m);
    return 8 >> m;
  endfunction

  task automatic do_mode(input logic [1:0] tgt);
    send(2'b10, '0, {6'b0, tgt}, 1'b1);
    wait_idle();
    chk("R2 command code", int'(cap_cmd), tgt == 2'd2 ? 'h38 : tgt == 2'd1 ? 'h3B : 'hFF);
    chk("R3 command clocks", cap_rises, slots(cur));
    chk("R2 lane_mode", int'(lane_mode), int'(tgt));
    cur = tgt;
  endtask

  task automatic do_write(input logic [16:0] a, input int n, input int base);
    for (int i = 0; i < n; i++) begin
      send(2'b01, a, 8'(base + i * 29), i == n - 1);
      exp_mem[8'(a + 17'(i))] = 8'(base + i * 29);
      repeat (i * 3) @(negedge clk);
    end
    wait_idle();
    chk("R4 write code", int'(cap_cmd), 'h02);
    chk("R4 write address", int'(cap_addr), int'(a));
    chk("R7 write clocks", cap_rises, (4 + n) * slots(cur));
  endtask

  task automatic do_read(input logic [16:0] a, input int n);
    int start;
    start = rd_total;
    for (int i = 0; i < n; i++) begin
      send(2'b00, a, 8'h00, i == n - 1);
      repeat (i * 2) @(negedge clk);
    end
    wait_idle();
    chk("R4 read code", int'(cap_cmd), 'h03);
    chk("R4 read address", int'(cap_addr), int'(a));
    chk("R6 read clocks", cap_rises, (5 + n) * slots(cur));
    chk("R8 byte count", rd_total - start, n);
    for (int i = 0; i < n; i++)
      chk("R8 R9 read data", int'(rd_buf[(start + i) % 64]), int'(exp_mem[8'(a + 17'(i))]));
  endtask

  function automatic logic [1:0] step_mode(input int s);
    case (s)
      1: return 2'd1;
      2: return 2'd2;
      3: return 2'd0;
      4: return 2'd2;
      5: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i * 7 + 3);
    cur = 2'd0;
    #3 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cs_n", int'(cs_n), 1);
    chk("R1 sck", int'(sck), 0);
    chk("R1 io_oe", int'(io_oe), 0);
    chk("R1 lane_mode", int'(lane_mode), 0);
    chk("R12 ready", int'(req_ready), 1);
    for (int s = 0; s < 7; s++) begin
      logic [16:0] a;
      a = 17'h1A5C0 + 17'(s * 16);
      if (s > 0) do_mode(step_mode(s));
      do_write(a, 3, s * 37 + 11);
      do_read(a - 17'd1, 4);
      do_read(a + 17'd5, 1);
    end
    chk("R6 lanes released in read", viol_dummy, 0);
    chk("R8 lane contention", viol_cont, 0);
    chk("R9 clock held in burst", viol_r9, 0);
    chk("R10 release and gap", viol_r10, 0);
    chk("R11 clock idle when deselected", viol_r11, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule